// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block watches the command bus of a four-bank synchronous DRAM and judges every clock's command against the device's protocol. It decodes the chip select, the three command strobes, the clock enable, the bank select and the twelve-bit address into one command. It follows the state of each bank: whether it is open, and which row is open in it. It also keeps per-bank cycle counts since the last activation and since the last precharge, plus a count since the last mode load.

Rule breaks are caught at the edge where the offending command is registered. They cover the ordering of commands and the minimum spacing between them. The first one latches an error flag and a four-bit code that hold until reset. All minimum spacings are parameters given in clock cycles.

Reads and writes that carry the auto-precharge qualifier close their bank on their own. The close happens at the end of the burst, using the burst length captured from the most recent mode load. The block is meant for a simulation or emulation harness placed beside a memory controller. It drives nothing onto the memory bus.

Top module: `sdramChk`

## Requirements
- R1: With csN high the cycle is an inhibit and has no effect, whatever the strobes carry; with csN low, rasN/casN/weN = 1/1/1 is a NOP and also has no effect. Neither raises an error or changes bank state.
- R2: ACTIVE (csN=0, rasN=0, casN=1, weN=1) opens the row on addr in bank ba. An ACTIVE to an open bank with a different row gives code 1; the same row gives no error.
- R3: READ (rasN=1, casN=0, weN=1) or WRITE (rasN=1, casN=0, weN=0) to an idle bank gives code 2.
- R4: PRECHARGE (rasN=0, casN=1, weN=0) with addr[10]=1 closes all banks and ignores ba. With addr[10]=0 it closes only bank ba.
- R5: AUTO REFRESH (rasN=0, casN=0, weN=1, with cke high or low) or LOAD MODE (all three low) while any bank is open gives code 3.
- R6: Any command other than NOP or inhibit registered fewer than T_MRD (default 2) edges after a LOAD MODE gives code 4.
- R7: READ or WRITE fewer than T_RCD (default 3) edges after ACTIVE to the same bank gives code 5.
- R8: ACTIVE to a bank fewer than T_RP (default 3) edges after it was closed, by an explicit or an automatic precharge, gives code 6. The same code is given for AUTO REFRESH or LOAD MODE within T_RP of any bank's close.
- R9: PRECHARGE of an open bank fewer than T_RAS (default 6) edges after its ACTIVE gives code 7.
- R10: ACTIVE to a bank fewer than T_RC (default 9) edges after its previous ACTIVE gives code 8.
- R11: READ or WRITE with addr[10]=1, registered at edge n, closes the bank at edge n+BL. Commands at edge n+BL still see the bank open. BL comes from the last LOAD MODE addr[2:0]: 0→1, 1→2, 2→4, 3→8, and 7 means full page with no automatic close. A WRITE uses BL=1 when that load had addr[9]=1.
- R12: The error flag and code are sticky until reset and keep the first violation. When one command breaks several rules, the lowest code is reported.
- R13: After reset the flag and code are 0, all banks are idle and every spacing counter counts as already satisfied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable; low with a refresh pattern means self refresh |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column, mode or qualifier bits |
| errFlag | output | 1 | Sticky violation flag |
| errCode | output | 4 | Code of the first violation (0 when none) |

## Verification
Two functions can fall on the same edge: the automatic close of one bank at the end of its burst, and an explicit command to another bank. The bench lines these up by issuing an auto-precharge read with burst length 2 and placing an ACTIVE to a second bank exactly two edges later. It then judges both effects at the ports: a later read of the second bank must pass, and a read of the first bank must report code 2. Sweeps over the gap between command pairs find the exact edge at which each spacing rule stops firing.

// File: rtl/sdramChkPkg.sv
package sdramChkPkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int ROW_W     = 12;
  localparam int CODE_W    = 4;
  localparam int NUM_RULES = 8;
  localparam int MAX_BURST = 8;

  typedef enum logic [3:0] {
    CMD_INHIBIT, CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE,
    CMD_STOP, CMD_PRE, CMD_REF, CMD_SREF, CMD_MRS
  } cmdT;

  typedef struct packed {
    logic              act;
    logic              pre;
    logic              preAll;
    logic              rw;
    logic              isWrite;
    logic              autoPre;
    logic              mrs;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  addr;
  } strobeT;
endpackage

// File: rtl/sdramChkBanks.sv
module sdramChkBanks
  import sdramChkPkg::*;
#(
  parameter int CNT_MAX = 9,
  parameter int CNT_W   = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobeT                             strb,
  output logic [NUM_BANKS-1:0]               bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]    openRow,
  output logic [NUM_BANKS-1:0][CNT_W-1:0]    sinceAct,
  output logic [NUM_BANKS-1:0][CNT_W-1:0]    sincePre,
  output logic [CNT_W-1:0]                   sinceMrs
);
  localparam int AP_W = $clog2(MAX_BURST + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [2:0]      blCode;
  logic            wrSingle;
  logic [AP_W-1:0] burstLen;
  logic [AP_W-1:0] apLen;
  logic            fullPage;

  // Mode capture and spacing count since the last mode load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blCode   <= 3'd0;
      wrSingle <= 1'b0;
      sinceMrs <= SAT;
    end else if (strb.mrs) begin
      blCode   <= strb.addr[2:0];
      wrSingle <= strb.addr[9];
      sinceMrs <= ONE;
    end else if (sinceMrs != SAT) begin
      sinceMrs <= sinceMrs + ONE;
    end
  end

  always_comb begin
    case (blCode)
      3'd1:    burstLen = AP_W'(2);
      3'd2:    burstLen = AP_W'(4);
      3'd3:    burstLen = AP_W'(8);
      default: burstLen = AP_W'(1);
    endcase
    fullPage = (blCode == 3'd7);
    apLen    = (strb.isWrite && wrSingle) ? AP_W'(1) : burstLen;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openQ;
    logic [ROW_W-1:0] rowQ;
    logic [CNT_W-1:0] actCnt;
    logic [CNT_W-1:0] preCnt;
    logic [AP_W-1:0]  apCnt;
    logic             hit;

    assign hit = (strb.bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ  <= 1'b0;
        rowQ   <= '0;
        actCnt <= SAT;
        preCnt <= SAT;
        apCnt  <= '0;
      end else begin
        if (actCnt != SAT) actCnt <= actCnt + ONE;
        if (preCnt != SAT) preCnt <= preCnt + ONE;
        if (strb.act && hit) begin
          openQ  <= 1'b1;
          rowQ   <= strb.addr;
          actCnt <= ONE;
          apCnt  <= '0;
        end else if (strb.pre && (strb.preAll || hit)) begin
          if (openQ) begin
            openQ  <= 1'b0;
            preCnt <= ONE;
          end
          apCnt <= '0;
        end else if (strb.rw && hit && openQ && strb.autoPre && !fullPage) begin
          apCnt <= apLen;
        end else if (apCnt == AP_W'(1)) begin
          openQ  <= 1'b0;
          preCnt <= ONE;
          apCnt  <= '0;
        end else if (apCnt != '0) begin
          apCnt <= apCnt - AP_W'(1);
        end
      end
    end

    assign bankOpen[b] = openQ;
    assign openRow[b]  = rowQ;
    assign sinceAct[b] = actCnt;
    assign sincePre[b] = preCnt;
  end
endmodule

// File: rtl/sdramChkCtrl.sv
module sdramChkCtrl
  import sdramChkPkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int T_MRD = 2,
  parameter int CNT_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            csN,
  input  logic                            rasN,
  input  logic                            casN,
  input  logic                            weN,
  input  logic                            cke,
  input  logic [BANK_W-1:0]               ba,
  input  logic [ROW_W-1:0]                addr,
  input  logic [NUM_BANKS-1:0]            bankOpen,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] sinceAct,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] sincePre,
  input  logic [CNT_W-1:0]                sinceMrs,
  output strobeT                          strb,
  output logic                            errFlag,
  output logic [CODE_W-1:0]               errCode
);
  localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] LIM_MRD = CNT_W'(T_MRD);

  cmdT                  cmd;
  logic                 isRw, isBusyCmd, tgtOpen;
  logic                 rasVio, rpAnyVio;
  logic [NUM_RULES-1:0] vio;
  logic [CODE_W-1:0]    firstCode;

  always_comb begin
    if (csN) cmd = CMD_INHIBIT;
    else begin
      case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_STOP;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

  assign isRw      = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign isBusyCmd = (cmd == CMD_REF) || (cmd == CMD_SREF) || (cmd == CMD_MRS);
  assign tgtOpen   = bankOpen[ba];

  always_comb begin
    strb         = '0;
    strb.act     = (cmd == CMD_ACT);
    strb.pre     = (cmd == CMD_PRE);
    strb.preAll  = addr[10];
    strb.rw      = isRw;
    strb.isWrite = (cmd == CMD_WRITE);
    strb.autoPre = addr[10];
    strb.mrs     = (cmd == CMD_MRS);
    strb.bank    = ba;
    strb.addr    = addr;
  end

  always_comb begin
    rasVio   = 1'b0;
    rpAnyVio = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if ((cmd == CMD_PRE) && (addr[10] || (ba == BANK_W'(b))) &&
          bankOpen[b] && (sinceAct[b] < LIM_RAS))
        rasVio = 1'b1;
      if (sincePre[b] < LIM_RP) rpAnyVio = 1'b1;
    end
    vio[0] = (cmd == CMD_ACT) && tgtOpen && (openRow[ba] != addr);
    vio[1] = isRw && !tgtOpen;
    vio[2] = isBusyCmd && (|bankOpen);
    vio[3] = (cmd != CMD_NOP) && (cmd != CMD_INHIBIT) && (sinceMrs < LIM_MRD);
    vio[4] = isRw && tgtOpen && (sinceAct[ba] < LIM_RCD);
    vio[5] = ((cmd == CMD_ACT) && (sincePre[ba] < LIM_RP)) || (isBusyCmd && rpAnyVio);
    vio[6] = rasVio;
    vio[7] = (cmd == CMD_ACT) && (sinceAct[ba] < LIM_RC);
    firstCode = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (vio[i]) firstCode = CODE_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errCode <= '0;
    end else if (!errFlag && (|vio)) begin
      errFlag <= 1'b1;
      errCode <= firstCode;
    end
  end
endmodule

// File: rtl/sdramChk.sv
module sdramChk
  import sdramChkPkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int T_MRD = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        cke,
  input  logic [1:0]  ba,
  input  logic [11:0] addr,
  output logic        errFlag,
  output logic [3:0]  errCode
);
  localparam int M1      = (T_RCD > T_RP)  ? T_RCD : T_RP;
  localparam int M2      = (T_RAS > T_RC)  ? T_RAS : T_RC;
  localparam int M3      = (M1 > M2)       ? M1    : M2;
  localparam int CNT_MAX = (M3 > T_MRD)    ? M3    : T_MRD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  strobeT                          strb;
  logic [NUM_BANKS-1:0]            bankOpen;
  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow;
  logic [NUM_BANKS-1:0][CNT_W-1:0] sinceAct;
  logic [NUM_BANKS-1:0][CNT_W-1:0] sincePre;
  logic [CNT_W-1:0]                sinceMrs;

  sdramChkCtrl #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_MRD(T_MRD), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .cke(cke), .ba(ba), .addr(addr),
    .bankOpen(bankOpen), .openRow(openRow), .sinceAct(sinceAct),
    .sincePre(sincePre), .sinceMrs(sinceMrs), .strb(strb),
    .errFlag(errFlag), .errCode(errCode)
  );

  sdramChkBanks #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) banks_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bankOpen(bankOpen),
    .openRow(openRow), .sinceAct(sinceAct), .sincePre(sincePre),
    .sinceMrs(sinceMrs)
  );
endmodule

// File: rtl/sdramChkAsserts.sv
module sdramChkAsserts (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        rasN,
  input logic        casN,
  input logic        weN,
  input logic [1:0]  ba,
  input logic [11:0] addr,
  input logic [3:0]  bankOpen,
  input logic        errFlag,
  input logic [3:0]  errCode
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && $stable(errCode))); // R12
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (errCode != 4'd0 && errCode <= 4'd8)); // R12
  AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |-> (errCode == 4'd0)); // R13
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && csN) |=> !errFlag); // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && weN) |=> bankOpen[$past(ba)]); // R2
  AST_RW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !csN && rasN && !casN && !bankOpen[ba]) |=>
      (errFlag && errCode == 4'd2)); // R3
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && casN && !weN && addr[10]) |=> (bankOpen == 4'd0)); // R4
  AST_BUSY_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !csN && !rasN && !casN && (|bankOpen)) |=>
      (errFlag && errCode == 4'd3)); // R5
endmodule

bind sdramChk sdramChkAsserts chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .addr(addr), .bankOpen(bankOpen),
  .errFlag(errFlag), .errCode(errCode)
);

// File: tb/sdramChk_tb_top.sv
`timescale 1ns/1ps
module sdramChk_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [11:0] addr = 12'd0;
  logic        errFlag;
  logic [3:0]  errCode;
  int          testsRun = 0;
  int          testsFailed = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sdramChk dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .cke(cke), .ba(ba), .addr(addr),
    .errFlag(errFlag), .errCode(errCode)
  );

  task automatic drive(input logic c, input logic r, input logic ca,
                       input logic w, input logic k, input logic [1:0] b,
                       input logic [11:0] a);
    @(negedge clk);
    csN = c; rasN = r; casN = ca; weN = w; cke = k; ba = b; addr = a;
  endtask

  task automatic nop(); drive(0, 1, 1, 1, 1, 2'd0, 12'd0); endtask
  task automatic gap(input int n); repeat (n) nop(); endtask
  task automatic act(input logic [1:0] b, input logic [11:0] row);
    drive(0, 0, 1, 1, 1, b, row);
  endtask
  task automatic rd(input logic [1:0] b, input logic ap);
    drive(0, 1, 0, 1, 1, b, ap ? 12'h400 : 12'h000);
  endtask
  task automatic wr(input logic [1:0] b, input logic ap);
    drive(0, 1, 0, 0, 1, b, ap ? 12'h400 : 12'h000);
  endtask
  task automatic pre(input logic [1:0] b, input logic all);
    drive(0, 0, 1, 0, 1, b, all ? 12'h400 : 12'h000);
  endtask
  task automatic refr(input logic k); drive(0, 0, 0, 1, k, 2'd0, 12'd0); endtask
  task automatic lmr(input logic [11:0] code); drive(0, 0, 0, 0, 1, 2'd0, code); endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    csN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; cke = 1'b1; ba = 0; addr = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Samples at the negedge following the last command's edge
  task automatic check(input string tag, input logic expF, input logic [3:0] expC);
    @(negedge clk);
    csN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; cke = 1'b1;
    testsRun++;
    if (errFlag !== expF || errCode !== expC) begin
      testsFailed++;
      $display("FAIL %s: got flag=%0b code=%0d, expected flag=%0b code=%0d",
               tag, errFlag, errCode, expF, expC);
    end
  endtask

  function automatic logic [3:0] expOf(input int code);
    return 4'(code);
  endfunction

  initial begin
    // R13: reset state and satisfied counters
    doReset();
    check("R13 reset", 0, 0);
    doReset();
    act(0, 12'd1); gap(2); rd(0, 0);
    check("R13 counters satisfied after reset", 0, 0);

    // R1: inhibit with every strobe pattern and both cke levels, then NOP
    doReset();
    act(3, 12'd7);
    for (int p = 0; p < 16; p++) drive(1, p[2], p[1], p[0], p[3], 2'd3, 12'h400);
    gap(2);
    rd(3, 0);
    check("R1 inhibit and NOP no effect", 0, 0);

    // R2: same row re-activate legal, different row is code 1
    doReset();
    act(0, 12'd5); gap(9); act(0, 12'd5);
    check("R2 same row", 0, 0);
    gap(9); act(0, 12'd6);
    check("R2 different row", 1, 1);

    // R3: read/write to each idle bank
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 2; w++) begin
        doReset();
        if (w == 1) wr(2'(b), 0); else rd(2'(b), 0);
        check("R3 access idle bank", 1, 2);
      end
    end

    // R4: single-bank precharge closes only the selected bank
    for (int sel = 0; sel < 4; sel++) begin
      doReset();
      for (int b = 0; b < 4; b++) act(2'(b), 12'(b));
      gap(6);
      pre(2'(sel), 0);
      gap(3);
      for (int b = 0; b < 4; b++) if (b != sel) rd(2'(b), 0);
      check("R4 other banks stay open", 0, 0);
      rd(2'(sel), 0);
      check("R4 selected bank closed", 1, 2);
    end
    for (int b = 0; b < 4; b++) begin
      doReset();
      for (int o = 0; o < 4; o++) act(2'(o), 12'd3);
      gap(6);
      pre(2'(3 - b), 1);
      gap(3);
      rd(2'(b), 0);
      check("R4 precharge all", 1, 2);
    end

    // R5: refresh / self refresh / mode load with open bank
    doReset();
    refr(1); gap(1); lmr(12'd0);
    check("R5 all idle legal", 0, 0);
    for (int v = 0; v < 3; v++) begin
      doReset();
      act(1, 12'd9); gap(6);
      if (v == 0) refr(1); else if (v == 1) refr(0); else lmr(12'd0);
      check("R5 busy bank", 1, 3);
    end

    // R6: tMRD sweep
    for (int k = 1; k <= 3; k++) begin
      doReset();
      lmr(12'd0); gap(k - 1); act(0, 12'd0);
      check("R6 tMRD gap", k < 2, (k < 2) ? expOf(4) : expOf(0));
    end

    // R7: tRCD sweep for read and write
    for (int w = 0; w < 2; w++) begin
      for (int k = 1; k <= 4; k++) begin
        doReset();
        act(1, 12'd2); gap(k - 1);
        if (w == 1) wr(1, 0); else rd(1, 0);
        check("R7 tRCD gap", k < 3, (k < 3) ? expOf(5) : expOf(0));
      end
    end

    // R9: tRAS sweep
    for (int k = 1; k <= 7; k++) begin
      doReset();
      act(2, 12'd4); gap(k - 1); pre(2, 0);
      check("R9 tRAS gap", k < 6, (k < 6) ? expOf(7) : expOf(0));
    end
    doReset();
    act(2, 12'd4); gap(4); pre(0, 1);
    check("R9 tRAS on precharge all", 1, 7);

    // R8: tRP sweep after explicit precharge
    for (int k = 1; k <= 4; k++) begin
      doReset();
      act(0, 12'd1); gap(5); pre(0, 0); gap(k - 1); act(0, 12'd1);
      check("R8 tRP gap", k < 3, (k < 3) ? expOf(6) : expOf(0));
    end

    // R10 and R8: re-activate after auto-precharge close (BL=1 from reset)
    for (int j = 1; j <= 6; j++) begin
      int ec;
      ec = (j < 3) ? 6 : ((j < 5) ? 8 : 0);
      doReset();
      act(0, 12'd1); gap(2); rd(0, 1); gap(j); act(0, 12'd1);
      check("R10 tRC / R8 tRP after auto close", ec != 0, expOf(ec));
    end

    // R11: burst-length sweep of the auto-precharge close edge
    for (int c = 0; c < 4; c++) begin
      int bl;
      bl = 1 << c;
      for (int m = 1; m <= bl + 1; m++) begin
        doReset();
        lmr(12'(c)); gap(1); act(1, 12'd8); gap(2); rd(1, 1); gap(m - 1); rd(1, 0);
        check("R11 auto close edge", m > bl, (m > bl) ? expOf(2) : expOf(0));
      end
    end
    doReset();
    lmr(12'd7); gap(1); act(1, 12'd8); gap(2); rd(1, 1); gap(8); rd(1, 0);
    check("R11 full page keeps bank open", 0, 0);
    for (int m = 1; m <= 2; m++) begin
      doReset();
      lmr(12'h203); gap(1); act(1, 12'd8); gap(2); wr(1, 1); gap(m - 1); wr(1, 0);
      check("R11 single-location write", m > 1, (m > 1) ? expOf(2) : expOf(0));
    end
    doReset();
    lmr(12'h203); gap(1); act(1, 12'd8); gap(2); rd(1, 1); gap(7); rd(1, 0);
    check("R11 read keeps BL8 under single write", 0, 0);

    // R11: auto close of bank 0 on the same edge as ACTIVE to bank 1
    doReset();
    lmr(12'd1); gap(1); act(0, 12'd2); gap(2); rd(0, 1); gap(1); act(1, 12'd3);
    gap(2); rd(1, 0);
    check("R11 concurrent close and activate, bank1", 0, 0);
    rd(0, 0);
    check("R11 concurrent close and activate, bank0", 1, 2);

    // R12: several rules in one command, then stickiness
    doReset();
    lmr(12'd0); rd(0, 0);
    check("R12 lowest code wins", 1, 2);
    act(0, 12'd1); gap(1); act(0, 12'd2);
    check("R12 first code kept", 1, 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule